// File: doc/BRIEF.md
# Cascadable Up/Down Pulse Counter

This block is a binary counter with two pulse inputs instead of a clock and a direction bit. A rising edge on the increment input adds one to the count. A rising edge on the decrement input subtracts one. Both inputs may come from slow or asynchronous sources. A synchronous clear returns the count to zero.

Two active-low terminal flags support chaining. The carry flag is low while the count sits at its maximum and the last step was upward. The borrow flag is low while the count sits at zero and the last step was downward. When the count wraps, the flag that was low goes high again. That low-to-high transition can feed the increment or decrement input of the next stage in a chain.

The whole block runs on one system clock. Each pulse input passes through a synchroniser and a rising-edge detector. A three-state direction machine records the last accepted step. Its states are `ST_IDLE` (no step since reset or clear), `ST_UP` (last step was an increment) and `ST_DOWN` (last step was a decrement). It has these transitions:
- any state goes to `ST_IDLE` on clear;
- any state goes to `ST_UP` on a lone increment edge;
- any state goes to `ST_DOWN` on a lone decrement edge;
- the state holds when both edges arrive in the same cycle, or when neither arrives.

Top module: `updn_tally`

## Requirements
- R1: Clear (`clr` high at a clock edge) sets the count to 0 and the state to `ST_IDLE`, so both `carry_n` and `borrow_n` are 1 on the following cycle.
- R2: Clear wins over both pulse inputs: an edge that reaches the counter while `clr` is high is lost, and the count stays 0.
- R3: Each rising edge on `inc_pulse` adds exactly one to the count, and 1111 wraps to 0000 (WIDTH=4).
- R4: `carry_n` is 0 exactly when the count is all ones and the state is `ST_UP`; otherwise it is 1.
- R5: An increment from all ones gives count 0 with `carry_n` returning to 1; this rising edge is the cascade step.
- R6: Each rising edge on `dec_pulse` subtracts exactly one, and 0000 wraps to 1111. From 1111, fifteen decrements reach 0000 and the sixteenth gives 1111.
- R7: `borrow_n` is 0 exactly when the count is 0 and the state is `ST_DOWN`; otherwise it is 1.
- R8: A decrement from 0 gives all ones with `borrow_n` returning to 1.
- R9: Increment and decrement edges detected in the same cycle are both ignored: the count, the state and both flags keep their values.
- R10: `carry_n` and `borrow_n` are never 0 at the same time.
- R11: An input held high for any number of cycles counts once. With SYNC_STAGES=2, the count changes at the third rising clock edge after the input rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear, has priority |
| inc_pulse | input | 1 | Increment pulse, counted on its rising edge |
| dec_pulse | input | 1 | Decrement pulse, counted on its rising edge |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low maximum-count flag after an increment |
| borrow_n | output | 1 | Active-low zero flag after a decrement |

## Verification
The bench builds the block with its default parameters: WIDTH=4 and SYNC_STAGES=2. With 16 count values, both wrap points are reached within a few pulses, so the full 15-then-16 decrement run and the maximum-count carry run are exercised directly. Random sequences of lone, simultaneous and clear operations are mixed into this. The two-stage synchroniser fixes the latency at three edges, which the bench checks cycle by cycle. Holding inputs high for several cycles and overlapping them with a long clear reaches the edge-only and priority cases.

// File: rtl/tally_pkg.sv
package tally_pkg;

    // Direction of the last accepted step.
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_UP   = 2'b01,
        ST_DOWN = 2'b10
    } dir_state_e;

endpackage

// File: rtl/tally_edge.sv
module tally_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic rise
);

    logic [SYNC_STAGES-1:0] chain_q;
    logic                   last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q[0] <= raw;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
            last_q <= chain_q[SYNC_STAGES-1];
        end
    end

    assign rise = chain_q[SYNC_STAGES-1] & ~last_q;

endmodule

// File: rtl/tally_core.sv
module tally_core
    import tally_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             up_ev,
    input  logic             dn_ev,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam logic [WIDTH-1:0] CNT_MAX = '1;
    localparam logic [WIDTH-1:0] CNT_ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    dir_state_e       state_q, state_d;
    logic [WIDTH-1:0] count_q, count_d;

    // Next-state and next-count logic.
    always_comb begin
        state_d = state_q;
        count_d = count_q;
        if (clr) begin
            state_d = ST_IDLE;
            count_d = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_UP, ST_DOWN: begin
                    if (up_ev && !dn_ev) begin
                        state_d = ST_UP;
                        count_d = count_q + CNT_ONE;
                    end else if (dn_ev && !up_ev) begin
                        state_d = ST_DOWN;
                        count_d = count_q - CNT_ONE;
                    end
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    // Output decode.
    always_comb begin
        count    = count_q;
        carry_n  = 1'b1;
        borrow_n = 1'b1;
        unique case (state_q)
            ST_UP:   carry_n  = (count_q != CNT_MAX);
            ST_DOWN: borrow_n = (count_q != '0);
            default: begin
                carry_n  = 1'b1;
                borrow_n = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/updn_tally.sv
module updn_tally #(
    parameter int WIDTH       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc_pulse,
    input  logic             dec_pulse,
    output logic [WIDTH-1:0] count,
    output logic             carry_n,
    output logic             borrow_n
);

    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] ev;

    assign raw_in = {dec_pulse, inc_pulse};

    for (genvar g = 0; g < N_IN; g++) begin : g_edge
        tally_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_in[g]),
            .rise (ev[g])
        );
    end

    tally_core #(.WIDTH(WIDTH)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .up_ev   (ev[0]),
        .dn_ev   (ev[1]),
        .count   (count),
        .carry_n (carry_n),
        .borrow_n(borrow_n)
    );

endmodule

// File: rtl/updn_tally_checker.sv
module updn_tally_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr,
    input logic [WIDTH-1:0] count,
    input logic             carry_n,
    input logic             borrow_n
);

    localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

    assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0) && carry_n && borrow_n);

    assert_unit_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (count == $past(count)) || (count == $past(count) + ONE) ||
                 (count == $past(count) - ONE) || (count == '0));

    assert_carry_at_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_n |-> (count == '1));

    assert_borrow_at_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !borrow_n |-> (count == '0));

    assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        carry_n || borrow_n);

endmodule

bind updn_tally updn_tally_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr),
    .count   (count),
    .carry_n (carry_n),
    .borrow_n(borrow_n)
);

// File: tb/updn_tally_bench.sv
module updn_tally_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         inc_pulse = 1'b0;
    logic         dec_pulse = 1'b0;
    logic [W-1:0] count;
    logic         carry_n, borrow_n;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Model: 0 = no step yet, 1 = last step up, 2 = last step down.
    logic [W-1:0] m_cnt = '0;
    int           m_dir = 0;

    always #2.5 clk = ~clk;

    updn_tally #(.WIDTH(W), .SYNC_STAGES(2)) u_updn_tally (
        .clk(clk), .rst_n(rst_n), .clr(clr),
        .inc_pulse(inc_pulse), .dec_pulse(dec_pulse),
        .count(count), .carry_n(carry_n), .borrow_n(borrow_n)
    );

    function automatic logic f_carry(logic [W-1:0] c, int d);
        return !((d == 1) && (c == '1));
    endfunction

    function automatic logic f_borrow(logic [W-1:0] c, int d);
        return !((d == 2) && (c == '0));
    endfunction

    task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic chk_all(string req);
        chk({req, " count"}, count, m_cnt);
        chk({req, " carry_n"}, {{(W-1){1'b0}}, carry_n}, {{(W-1){1'b0}}, f_carry(m_cnt, m_dir)});
        chk({req, " borrow_n"}, {{(W-1){1'b0}}, borrow_n}, {{(W-1){1'b0}}, f_borrow(m_cnt, m_dir)});
        chk({req, " R10 exclusive"}, {{(W-1){1'b0}}, (carry_n | borrow_n)}, {{(W-1){1'b0}}, 1'b1});
    endtask

    task automatic step(bit up, bit dn, int hold);
        @(negedge clk);
        inc_pulse = up;
        dec_pulse = dn;
        repeat (hold) @(negedge clk);
        inc_pulse = 1'b0;
        dec_pulse = 1'b0;
        repeat (4) @(negedge clk);
        if (up && !dn) begin
            m_cnt = m_cnt + 1'b1;
            m_dir = 1;
        end else if (dn && !up) begin
            m_cnt = m_cnt - 1'b1;
            m_dir = 2;
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        m_cnt = '0;
        m_dir = 0;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_all("R1 reset");

        // R11: latency of exactly three edges, held input counts once.
        @(negedge clk);
        inc_pulse = 1'b1;
        @(negedge clk);
        chk("R11 edge1", count, 4'd0);
        @(negedge clk);
        chk("R11 edge2", count, 4'd0);
        @(negedge clk);
        chk("R11 edge3", count, 4'd1);
        repeat (8) @(negedge clk);
        inc_pulse = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 held once", count, 4'd1);
        m_cnt = 4'd1;
        m_dir = 1;
        chk_all("R3 first up");

        // R3/R4/R5: climb to max, then wrap up.
        while (m_cnt != 4'hF) step(1'b1, 1'b0, 1);
        chk_all("R4 carry low at max");
        step(1'b1, 1'b0, 2);
        chk_all("R5 wrap up carry released");

        // R9: simultaneous edges ignored.
        step(1'b1, 1'b1, 3);
        chk_all("R9 both ignored");

        // R6/R7/R8: from all ones, 15 downs reach zero, 16th wraps.
        do_clear();
        step(1'b0, 1'b1, 1);
        chk_all("R6 zero to max");
        for (int i = 0; i < 15; i++) step(1'b0, 1'b1, 1);
        chk_all("R7 borrow low at zero");
        chk("R6 fifteen downs", count, 4'd0);
        step(1'b0, 1'b1, 1);
        chk_all("R8 wrap down borrow released");
        chk("R6 sixteenth down", count, 4'hF);

        // R1: clear from a nonzero count.
        do_clear();
        chk_all("R1 clear");

        // R2: clear held across an arriving increment edge.
        step(1'b1, 1'b0, 1);
        step(1'b1, 1'b0, 1);
        @(negedge clk);
        clr = 1'b1;
        inc_pulse = 1'b1;
        repeat (5) @(negedge clk);
        inc_pulse = 1'b0;
        @(negedge clk);
        clr = 1'b0;
        m_cnt = '0;
        m_dir = 0;
        repeat (3) @(negedge clk);
        chk_all("R2 clear priority");

        // Random mix.
        for (int k = 0; k < 300; k++) begin
            int sel;
            int hold;
            sel  = int'($urandom_range(0, 9));
            hold = int'($urandom_range(1, 5));
            if (sel < 4)       step(1'b1, 1'b0, hold);
            else if (sel < 8)  step(1'b0, 1'b1, hold);
            else if (sel == 8) step(1'b1, 1'b1, hold);
            else               do_clear();
            chk_all("R3 R6 R9 random");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule